// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that works through a chain of descriptors held in memory. Software enables the channel, loads the address of the first descriptor and rings a doorbell. The channel then reads the descriptor, which is eight 32-bit words, and checks its valid flag. It copies the requested number of bytes from the source address to the destination address, one word at a time. It then records completion as the descriptor asks and follows the link to the next descriptor. The chain ends when the channel meets a descriptor whose valid flag is clear. The channel halts there and waits for another doorbell.

Descriptor word layout, by word offset: 0 command (flags), 1 byte count, 2 source address, 3 unused, 4 destination address, 5 and 6 unused, 7 link. All channel traffic goes through one word-wide memory port that uses a request/grant handshake. Read data is returned in the grant cycle. Software reaches the channel through a small register port: write strobe, word index, write data, and combinational read data.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low. The register word indices are: 0 control (bit 0 enable), 1 descriptor address, 2 doorbell (write only), 3 pending flag (bit 0), 4 status (bit 2 doorbell seen, bit 1 descriptor valid, bit 0 halted), 5 remaining byte count.
- R2: A doorbell write while control bit 0 is clear has no effect. No memory request is made and the status does not change.
- R3: An accepted doorbell sets status bit 2 and clears bit 0. The channel then reads the eight descriptor words at increasing word addresses, starting at the descriptor address register.
- R4: If command bit 31 of a fetched descriptor is clear, the channel stops with no further memory traffic. Status then reads 1: halted set, valid and doorbell bits clear.
- R5: The byte count is bits 21:0 of word 1 (a multiple of 4). The channel copies it as word reads from the source, each followed by a write of the same data to the destination, with both addresses rising by 4. A count of zero moves nothing.
- R6: Command bits 1:0 choose the completion write to descriptor offset 24: 0 no write, 1 the status register value, 2 the command word with bit 31 cleared, 3 the remaining byte count (zero).
- R7: When command bit 2 is set, the channel writes the command word with bit 31 cleared back to descriptor offset 0. This write comes after the completion write.
- R8: The next descriptor address is bits 26:0 of word 7 shifted left by 5. It is visible in the descriptor address register.
- R9: Every completed descriptor sets the pending flag. `irq` equals the pending flag ANDed with command bit 8 of the last completed descriptor. Writing 1 to pending bit 0 clears it.
- R10: A doorbell accepted while the channel is busy is held. When the chain halts, the channel fetches again from the current descriptor address instead of halting.
- R11: `mem_req` stays high with a stable address, direction and write data until `mem_gnt`. Every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; completes the access |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a few things about the environment:
- software writes the descriptor address only while the channel is halted;
- byte counts are multiples of four;
- the memory answers each request eventually, with read data valid in the grant cycle.

The bench follows all of these:
- it programs registers and descriptor memory only after polling the halted bit;
- every count it uses is a word multiple;
- its memory model grants two cycles out of every three, which exercises the hold rule without ever stalling forever.

// File: rtl/dma_chain_channel.sv
module dma_chain_channel #(
  parameter int BC_W = 22,
  parameter int LINK_W = 27
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  localparam int SHIFT = 32 - LINK_W;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_READ, S_WRITE, S_WB, S_CV, S_DONE} state_t;
  state_t state;

  logic              cfg_en, irq_pend, ie_last, db_pend;
  logic              st_db, st_valid, st_halt;
  logic [31:0]       ptr, cmd0, src, dst, cur_src, cur_dst, wbuf;
  logic [BC_W-1:0]   cnt, remaining;
  logic [LINK_W-1:0] link;
  logic [2:0]        widx;

  wire db_hit   = reg_we && reg_addr == 3'd2 && cfg_en;
  wire invalid  = !cmd0[31];
  wire restart  = db_pend || db_hit;
  wire [31:0] status_word = {29'b0, st_db, st_valid, st_halt};

  assign irq = irq_pend && ie_last;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {31'b0, cfg_en};
      3'd1:    reg_rdata = ptr;
      3'd3:    reg_rdata = {31'b0, irq_pend};
      3'd4:    reg_rdata = status_word;
      3'd5:    reg_rdata = {{(32-BC_W){1'b0}}, remaining};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_comb begin
    mem_req = 1'b0;
    mem_we = 1'b0;
    mem_addr = 32'b0;
    mem_wdata = 32'b0;
    case (state)
      S_FETCH: begin
        mem_req = 1'b1;
        mem_addr = ptr + {27'b0, widx, 2'b00};
      end
      S_READ: begin
        mem_req = 1'b1;
        mem_addr = cur_src;
      end
      S_WRITE: begin
        mem_req = 1'b1;
        mem_we = 1'b1;
        mem_addr = cur_dst;
        mem_wdata = wbuf;
      end
      S_WB: begin
        mem_req = cmd0[1:0] != 2'd0;
        mem_we = 1'b1;
        mem_addr = ptr + 32'd24;
        case (cmd0[1:0])
          2'd1:    mem_wdata = status_word;
          2'd2:    mem_wdata = {1'b0, cmd0[30:0]};
          2'd3:    mem_wdata = {{(32-BC_W){1'b0}}, remaining};
          default: mem_wdata = 32'b0;
        endcase
      end
      S_CV: begin
        mem_req = cmd0[2];
        mem_we = 1'b1;
        mem_addr = ptr;
        mem_wdata = {1'b0, cmd0[30:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cfg_en <= 1'b0;
      ptr <= 32'b0;
      irq_pend <= 1'b0;
      ie_last <= 1'b0;
      db_pend <= 1'b0;
      st_db <= 1'b0;
      st_valid <= 1'b0;
      st_halt <= 1'b0;
      cmd0 <= 32'b0;
      cnt <= '0;
      src <= 32'b0;
      dst <= 32'b0;
      link <= '0;
      cur_src <= 32'b0;
      cur_dst <= 32'b0;
      wbuf <= 32'b0;
      remaining <= '0;
      widx <= 3'd0;
    end else begin
      if (reg_we && reg_addr == 3'd0) cfg_en <= reg_wdata[0];
      if (reg_we && reg_addr == 3'd1) ptr <= reg_wdata;
      if (reg_we && reg_addr == 3'd3 && reg_wdata[0]) irq_pend <= 1'b0;
      if (db_hit && state != S_IDLE && !(state == S_CHECK && invalid)) db_pend <= 1'b1;
      case (state)
        S_IDLE: if (db_hit) begin
          st_db <= 1'b1;
          st_halt <= 1'b0;
          widx <= 3'd0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_gnt) begin
          case (widx)
            3'd0: cmd0 <= mem_rdata;
            3'd1: cnt <= mem_rdata[BC_W-1:0];
            3'd2: src <= mem_rdata;
            3'd4: dst <= mem_rdata;
            3'd7: link <= mem_rdata[LINK_W-1:0];
            default: ;
          endcase
          widx <= widx + 3'd1;
          if (widx == 3'd7) state <= S_CHECK;
        end
        S_CHECK: begin
          if (invalid) begin
            st_valid <= 1'b0;
            if (restart) begin
              db_pend <= 1'b0;
              widx <= 3'd0;
              state <= S_FETCH;
            end else begin
              st_halt <= 1'b1;
              st_db <= 1'b0;
              state <= S_IDLE;
            end
          end else begin
            st_valid <= 1'b1;
            cur_src <= src;
            cur_dst <= dst;
            remaining <= cnt;
            state <= (cnt == '0) ? S_WB : S_READ;
          end
        end
        S_READ: if (mem_gnt) begin
          wbuf <= mem_rdata;
          state <= S_WRITE;
        end
        S_WRITE: if (mem_gnt) begin
          cur_src <= cur_src + 32'd4;
          cur_dst <= cur_dst + 32'd4;
          remaining <= (remaining > BC_W'(4)) ? remaining - BC_W'(4) : '0;
          state <= (remaining > BC_W'(4)) ? S_READ : S_WB;
        end
        S_WB: if (!mem_req || mem_gnt) state <= S_CV;
        S_CV: if (!mem_req || mem_gnt) state <= S_DONE;
        S_DONE: begin
          irq_pend <= 1'b1;
          ie_last <= cmd0[8];
          ptr <= {link, {SHIFT{1'b0}}};
          widx <= 3'd0;
          state <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R11
  AST_DISABLED_DB: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && reg_we && reg_addr == 3'd2 && !cfg_en |=> !mem_req); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CHECK && invalid && !restart |=> !mem_req && reg_rdata_halt_ok); // R4
  AST_PEND_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DONE |=> irq_pend); // R9
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WRITE && mem_gnt && remaining > BC_W'(4) |=> remaining == $past(remaining) - BC_W'(4)); // R5
  AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && db_hit |=> mem_req && !mem_we && mem_addr == $past(ptr)); // R3

  wire reg_rdata_halt_ok = st_halt && !st_db && !st_valid;
endmodule

// File: tb/dma_chain_channel_test.sv
module dma_chain_channel_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'b0, reg_rdata;
  logic mem_req, mem_we, mem_gnt, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [256];
  int tick = 0;
  int nchk = 0, nfail = 0;
  int req_seen = 0, fetch_a0 = 0;
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq));

  assign mem_gnt = mem_req && (tick % 3 != 2);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    tick <= tick + 1;
    if (mem_req && mem_we && mem_gnt) mem[mem_addr[9:2]] <= mem_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design issues them
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      req_seen++;
      if (mem_gnt && !mem_we && mem_addr == 32'h0A0) fetch_a0++;
      if (mem_gnt && mem_we) begin
        if (exp_addr.size() == 0) begin
          check("R5/R6/R7 unexpected write addr", mem_addr, 32'hFFFFFFFF);
        end else begin
          check("R5/R6/R7 write address", mem_addr, exp_addr.pop_front());
          check("R5/R6/R7 write data", mem_wdata, exp_data.pop_front());
        end
      end
    end
  end

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
    exp_addr.push_back(a);
    exp_data.push_back(d);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_halt();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      reg_read(3'd4, s);
      if (s[0]) return;
    end
    check("R4 halt timeout", 32'h0, 32'h1);
  endtask

  task automatic put_desc(input int base, input logic [31:0] c0, input logic [31:0] c1,
                          input logic [31:0] s, input logic [31:0] d, input logic [31:0] nxt);
    mem[base/4 + 0] = c0; mem[base/4 + 1] = c1; mem[base/4 + 2] = s;
    mem[base/4 + 4] = d;  mem[base/4 + 7] = nxt;
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 32'b0;
    for (int i = 0; i < 32; i++) mem[128 + i] = 32'hA5000000 + i;
    put_desc(32'h000, 32'h80000101, 32'hFFC00008, 32'h200, 32'h300, 32'h1);
    put_desc(32'h020, 32'h80000006, 32'h00000004, 32'h208, 32'h310, 32'h2);
    put_desc(32'h040, 32'h80000003, 32'h0000000C, 32'h20C, 32'h320, 32'h3);
    put_desc(32'h060, 32'h80000100, 32'h00000000, 32'h230, 32'h330, 32'h4);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_read(3'd4, v); check("R1 status reset", v, 32'h0);
    reg_read(3'd5, v); check("R1 count reset", v, 32'h0);
    reg_read(3'd1, v); check("R1 ptr reset", v, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);

    reg_write(3'd2, 32'h1);
    repeat (20) @(negedge clk);
    check("R2 no request while disabled", req_seen, 0);
    reg_read(3'd4, v); check("R2 status unchanged", v, 32'h0);

    expect_wr(32'h300, 32'hA5000000);
    expect_wr(32'h304, 32'hA5000001);
    expect_wr(32'h018, 32'h00000006);
    expect_wr(32'h310, 32'hA5000002);
    expect_wr(32'h038, 32'h00000006);
    expect_wr(32'h020, 32'h00000006);
    expect_wr(32'h320, 32'hA5000003);
    expect_wr(32'h324, 32'hA5000004);
    expect_wr(32'h328, 32'hA5000005);
    expect_wr(32'h058, 32'h00000000);
    reg_write(3'd0, 32'h1);
    reg_write(3'd1, 32'h0);
    reg_write(3'd2, 32'h1);
    reg_read(3'd4, v); check("R3 doorbell bit set", {29'b0, v[2:0]} & 32'h5, 32'h4);
    wait_halt();
    reg_read(3'd4, v); check("R4 halted status", v, 32'h1);
    reg_read(3'd1, v); check("R8 next pointer", v, 32'h080);
    reg_read(3'd3, v); check("R9 pending after chain", v, 32'h1);
    check("R9 irq with enable", {31'b0, irq}, 32'h1);
    check("R5 queue drained", exp_addr.size(), 0);
    check("R7 descriptor valid cleared", mem[32'h020/4], 32'h00000006);

    reg_write(3'd3, 32'h1);
    reg_read(3'd3, v); check("R9 pending cleared", v, 32'h0);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);

    put_desc(32'h080, 32'h80000000, 32'h00000004, 32'h240, 32'h340, 32'h5);
    expect_wr(32'h340, 32'hA5000010);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1;
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    wait_halt();
    check("R10 relaunch refetched halt descriptor", fetch_a0, 2);
    reg_read(3'd1, v); check("R10 pointer at halt", v, 32'h0A0);
    reg_read(3'd3, v); check("R9 pending second run", v, 32'h1);
    check("R9 irq masked by command bit 8", {31'b0, irq}, 32'h0);
    reg_read(3'd5, v); check("R5 remaining count idle", v, 32'h0);
    check("R5 second run drained", exp_addr.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule